// File: doc/BRIEF.md
# Serpentine Systolic 2-D Convolution Array

This block computes a two-dimensional convolution of an ARR x ARR image tile with a KSIZE x KSIZE kernel of signed coefficients. A processing element sits at every output pixel and keeps a signed accumulator. One kernel coefficient is broadcast to all elements per clock. The image pixels step between neighbouring elements so that, together, they trace the kernel offsets along a snake path. The path sweeps one kernel row in one direction, drops one row, and sweeps back. Each step is one multiply-add in every element, so a tile takes exactly KSIZE*KSIZE compute cycles whatever the coefficients are.

Image I/O runs while the array computes. Each element has a load register that can be written from a row bus (a whole row per cycle) and a column bus (a whole column per cycle), both in the same cycle. A start pulse copies the load plane into the working plane and clears the accumulators, which frees the load plane for the next tile at once. After the last multiply-add a one-cycle done pulse is raised and the results move into an unload plane. The unload plane is read one row per request, with every column of the row on its own lane, until the next tile finishes. To the right of the array, KSIZE-1 pixel-only columns keep the pixels that the rightward sweeps push past the edge, so no pixel of the tile is lost when a sweep turns back.

Top module: `smesh_conv_top`

## Requirements
- R1: After reset, busy, done and rd_valid are low, and every unload result reads as zero.
- R2: Each result is out[r][c] = sum over i,j in 0..KSIZE-1 of kern[i*KSIZE+j] * img[r-i][c-j]. Pixels are unsigned, and a pixel outside the tile counts as zero. The sum is exact, signed and never saturated, and is returned in ACC_W bits.
- R3: A start taken while idle raises busy in the next cycle. Busy stays high for exactly KSIZE*KSIZE cycles. Done is high for exactly one cycle, the cycle right after busy falls.
- R4: A start pulse while busy is ignored: the running tile keeps its timing and its results.
- R5: When row_we is high, pixel c of row_data (bits c*8 upward) goes to load row row_sel. When col_we is high, pixel r of col_data goes to load column col_sel. Both can be used in one cycle, and at the element where they meet the column bus wins.
- R6: Loads made while busy go to the next tile only. The results of the running tile use the plane as it was when its start was taken. A write in the cycle of the start also belongs to the next tile.
- R7: rd_en with rd_row gives rd_valid and rd_data in the next cycle, with column c at bits c*ACC_W upward. Results stay readable from the cycle after done until the next done, including while the next tile computes.
- R8: k_we writes the signed coefficient k_data to tap k_addr = i*KSIZE+j. The taps are kept until they are rewritten.
- R9: A start does not consume the load plane. A second start with no new loads convolves the same tile again, with the kernel that holds at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile (taken only while idle) |
| busy | output | 1 | Multiply-add sequence running |
| done | output | 1 | One-cycle pulse after the last multiply-add |
| k_we | input | 1 | Kernel tap write strobe |
| k_addr | input | $clog2(KSIZE*KSIZE) | Tap index i*KSIZE+j |
| k_data | input | COEF_W | Signed coefficient |
| row_we | input | 1 | Row bus write strobe |
| row_sel | input | $clog2(ARR) | Load row index |
| row_data | input | ARR*PIX_W | One pixel per column |
| col_we | input | 1 | Column bus write strobe |
| col_sel | input | $clog2(ARR) | Load column index |
| col_data | input | ARR*PIX_W | One pixel per row |
| rd_en | input | 1 | Unload row request |
| rd_row | input | $clog2(ARR) | Unload row index |
| rd_valid | output | 1 | rd_data holds the requested row |
| rd_data | output | ARR*ACC_W | Signed results, one lane per column |

## Verification
The checker assumes that the kernel is written only while the array is idle. It assumes that start is a plain level sampled each cycle, so a pulse during a run may occur and must be ignored. The bench keeps to this by writing taps only between tiles, after done, and it deliberately drives a start in the middle of a run. Row and column bus writes, and unload reads, are allowed in any cycle. The stimulus puts them inside running tiles, in the start cycle and in the done cycle, so the timing rules on when a write belongs to the next tile are exercised.

// File: rtl/smesh_pkg.sv
package smesh_pkg;
  // Source a working pixel takes on the next clock.
  typedef enum logic [1:0] {
    MV_HOLD       = 2'd0,
    MV_FROM_LEFT  = 2'd1,
    MV_FROM_RIGHT = 2'd2,
    MV_FROM_UP    = 2'd3
  } move_e;
endpackage

// File: rtl/smesh_seq.sv
module smesh_seq
  import smesh_pkg::*;
#(
  parameter int KSIZE  = 3,
  parameter int COEF_W = 8,
  parameter int TAPS   = KSIZE * KSIZE,
  parameter int IDX_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     k_we,
  input  logic [IDX_W-1:0]         k_addr,
  input  logic signed [COEF_W-1:0] k_data,
  output logic                     go,
  output logic                     busy,
  output logic                     done,
  output logic                     mac_en,
  output move_e                    move,
  output logic signed [COEF_W-1:0] coef
);
  localparam int CNT_W = (KSIZE > 1) ? $clog2(KSIZE) : 1;

  logic                     busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0]         ic_q, ic_d, jc_q, jc_d;
  logic signed [COEF_W-1:0] kmem_q [TAPS];
  logic signed [COEF_W-1:0] kmem_d [TAPS];
  logic                     last_col, last_row;
  logic [IDX_W-1:0]         row_base, col_ofs, tap;

  assign go       = start & ~busy_q;
  assign last_col = (jc_q == CNT_W'(KSIZE - 1));
  assign last_row = (ic_q == CNT_W'(KSIZE - 1));

  // Snake walk: even kernel rows sweep j upward, odd rows sweep back.
  always_comb begin
    busy_d = busy_q;
    ic_d   = ic_q;
    jc_d   = jc_q;
    done_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      ic_d   = '0;
      jc_d   = '0;
    end else if (busy_q) begin
      if (!last_col) begin
        jc_d = jc_q + 1'b1;
      end else if (!last_row) begin
        ic_d = ic_q + 1'b1;
        jc_d = '0;
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_comb begin
    for (int t = 0; t < TAPS; t++) kmem_d[t] = kmem_q[t];
    if (k_we && (int'(k_addr) < TAPS)) kmem_d[k_addr] = k_data;
  end

  always_comb begin
    row_base = IDX_W'(ic_q) * IDX_W'(KSIZE);
    col_ofs  = ic_q[0] ? (IDX_W'(KSIZE - 1) - IDX_W'(jc_q)) : IDX_W'(jc_q);
    tap      = row_base + col_ofs;
    coef     = kmem_q[tap];
    mac_en   = busy_q;
    move     = MV_HOLD;
    if (busy_q && !last_col)      move = ic_q[0] ? MV_FROM_RIGHT : MV_FROM_LEFT;
    else if (busy_q && !last_row) move = MV_FROM_UP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ic_q   <= '0;
      jc_q   <= '0;
      for (int t = 0; t < TAPS; t++) kmem_q[t] <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ic_q   <= ic_d;
      jc_q   <= jc_d;
      for (int t = 0; t < TAPS; t++) kmem_q[t] <= kmem_d[t];
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/smesh_pe.sv
module smesh_pe
  import smesh_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PIX_W-1:0]         wr_pix,
  input  logic                     start,
  input  logic                     mac_en,
  input  move_e                    move,
  input  logic [PIX_W-1:0]         left_pix,
  input  logic [PIX_W-1:0]         right_pix,
  input  logic [PIX_W-1:0]         up_pix,
  input  logic signed [COEF_W-1:0] coef,
  input  logic                     latch,
  output logic [PIX_W-1:0]         work_pix,
  output logic signed [ACC_W-1:0]  result
);
  localparam int PROD_W = PIX_W + COEF_W + 1;

  logic [PIX_W-1:0]         load_q, load_d, work_q, work_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d, res_q, res_d;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    load_d = wr_en ? wr_pix : load_q;
    work_d = work_q;
    if (start) work_d = load_q;
    else begin
      case (move)
        MV_FROM_LEFT:  work_d = left_pix;
        MV_FROM_RIGHT: work_d = right_pix;
        MV_FROM_UP:    work_d = up_pix;
        default:       work_d = work_q;
      endcase
    end
    prod  = $signed({1'b0, work_q}) * coef;
    acc_d = acc_q;
    if (start)       acc_d = '0;
    else if (mac_en) acc_d = acc_q + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    res_d = latch ? acc_q : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      work_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      load_q <= load_d;
      work_q <= work_d;
      acc_q  <= acc_d;
      res_q  <= res_d;
    end
  end

  assign work_pix = work_q;
  assign result   = res_q;
endmodule

// File: rtl/smesh_halo.sv
module smesh_halo
  import smesh_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  move_e            move,
  input  logic [PIX_W-1:0] left_pix,
  input  logic [PIX_W-1:0] right_pix,
  input  logic [PIX_W-1:0] up_pix,
  output logic [PIX_W-1:0] work_pix
);
  logic [PIX_W-1:0] work_q, work_d;

  // Outside the tile: starts at zero, then only carries shifted pixels.
  always_comb begin
    work_d = work_q;
    if (start) work_d = '0;
    else begin
      case (move)
        MV_FROM_LEFT:  work_d = left_pix;
        MV_FROM_RIGHT: work_d = right_pix;
        MV_FROM_UP:    work_d = up_pix;
        default:       work_d = work_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_q <= '0;
    else        work_q <= work_d;
  end

  assign work_pix = work_q;
endmodule

// File: rtl/smesh_conv_top.sv
module smesh_conv_top
  import smesh_pkg::*;
#(
  parameter int ARR    = 16,
  parameter int KSIZE  = 3,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = PIX_W + COEF_W + 1 + $clog2(KSIZE * KSIZE)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  output logic                                 busy,
  output logic                                 done,
  input  logic                                 k_we,
  input  logic [$clog2(KSIZE*KSIZE)-1:0]       k_addr,
  input  logic signed [COEF_W-1:0]             k_data,
  input  logic                                 row_we,
  input  logic [$clog2(ARR)-1:0]               row_sel,
  input  logic [ARR*PIX_W-1:0]                 row_data,
  input  logic                                 col_we,
  input  logic [$clog2(ARR)-1:0]               col_sel,
  input  logic [ARR*PIX_W-1:0]                 col_data,
  input  logic                                 rd_en,
  input  logic [$clog2(ARR)-1:0]               rd_row,
  output logic                                 rd_valid,
  output logic [ARR*ACC_W-1:0]                 rd_data
);
  localparam int TAPS  = KSIZE * KSIZE;
  localparam int SEL_W = $clog2(ARR);
  localparam int HALO  = KSIZE - 1;
  localparam int WCOLS = ARR + HALO;

  logic                     go, mac_en, rd_valid_q;
  move_e                    move;
  logic signed [COEF_W-1:0] coef;
  logic [PIX_W-1:0]         work_w [ARR][WCOLS];
  logic signed [ACC_W-1:0]  res_w  [ARR][ARR];
  logic [ARR*ACC_W-1:0]     rd_mux, rd_data_q;

  smesh_seq #(.KSIZE(KSIZE), .COEF_W(COEF_W)) u_seq (
    .clk, .rst_n, .start, .k_we, .k_addr, .k_data,
    .go, .busy, .done, .mac_en, .move, .coef
  );

  for (genvar r = 0; r < ARR; r++) begin : g_row
    for (genvar c = 0; c < WCOLS; c++) begin : g_col
      logic [PIX_W-1:0] lft, rgt, upv;
      if (c == 0) begin : g_l0
        assign lft = '0;
      end else begin : g_l
        assign lft = work_w[r][c-1];
      end
      if (c == WCOLS - 1) begin : g_r0
        assign rgt = '0;
      end else begin : g_r
        assign rgt = work_w[r][c+1];
      end
      if (r == 0) begin : g_u0
        assign upv = '0;
      end else begin : g_u
        assign upv = work_w[r-1][c];
      end

      if (c < ARR) begin : g_pe
        logic hit_col, hit_row;
        logic [PIX_W-1:0] wpix;
        assign hit_col = col_we && (col_sel == SEL_W'(c));
        assign hit_row = row_we && (row_sel == SEL_W'(r));
        assign wpix    = hit_col ? col_data[r*PIX_W +: PIX_W] : row_data[c*PIX_W +: PIX_W];
        smesh_pe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_pe (
          .clk, .rst_n,
          .wr_en    (hit_col | hit_row),
          .wr_pix   (wpix),
          .start    (go),
          .mac_en,
          .move,
          .left_pix (lft),
          .right_pix(rgt),
          .up_pix   (upv),
          .coef,
          .latch    (done),
          .work_pix (work_w[r][c]),
          .result   (res_w[r][c])
        );
      end else begin : g_halo
        smesh_halo #(.PIX_W(PIX_W)) u_halo (
          .clk, .rst_n,
          .start    (go),
          .move,
          .left_pix (lft),
          .right_pix(rgt),
          .up_pix   (upv),
          .work_pix (work_w[r][c])
        );
      end
    end
  end

  always_comb begin
    for (int c = 0; c < ARR; c++) rd_mux[c*ACC_W +: ACC_W] = res_w[rd_row][c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/smesh_conv_chk.sv
module smesh_conv_chk #(
  parameter int TAPS = 9
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic k_we,
  input logic rd_en,
  input logic rd_valid
);
  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  assert_busy_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == TAPS));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R4: a start during a run never stretches it beyond TAPS cycles.
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < TAPS));

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // Input rule: taps change only between tiles.
  assert_kernel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    k_we |-> !busy);
endmodule

bind smesh_conv_top smesh_conv_chk #(.TAPS(KSIZE * KSIZE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .k_we     (k_we),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/smesh_conv_top_bench.sv
module smesh_conv_top_bench;
  localparam int ARR    = 4;
  localparam int KSIZE  = 3;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 8;
  localparam int TAPS   = KSIZE * KSIZE;
  localparam int ACC_W  = PIX_W + COEF_W + 1 + $clog2(TAPS);
  localparam int SEL_W  = $clog2(ARR);
  localparam int IDX_W  = $clog2(TAPS);
  localparam int DW     = ARR * ACC_W;

  logic clk = 1'b0;
  logic rst_n;
  logic start, busy, done, k_we, row_we, col_we, rd_en, rd_valid;
  logic [IDX_W-1:0] k_addr;
  logic signed [COEF_W-1:0] k_data;
  logic [SEL_W-1:0] row_sel, col_sel, rd_row;
  logic [ARR*PIX_W-1:0] row_data, col_data;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  smesh_conv_top #(.ARR(ARR), .KSIZE(KSIZE), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_smesh_conv_top (
    .clk, .rst_n, .start, .busy, .done, .k_we, .k_addr, .k_data,
    .row_we, .row_sel, .row_data, .col_we, .col_sel, .col_data,
    .rd_en, .rd_row, .rd_valid, .rd_data
  );

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R1";
  string cur_ctl = "R3";
  bit checking = 1'b0;

  // Behavioural model state
  int  m_plane [ARR][ARR];
  int  m_snap  [ARR][ARR];
  int  m_kern  [TAPS];
  int  m_ksnap [TAPS];
  int  m_pend  [ARR][ARR];
  int  m_res   [ARR][ARR];
  bit  m_busy, m_done, m_rv;
  int  m_left;
  logic [DW-1:0] m_rd;

  function automatic int conv_at(int r, int c);
    int s = 0;
    for (int i = 0; i < KSIZE; i++)
      for (int j = 0; j < KSIZE; j++)
        if (r - i >= 0 && c - j >= 0) s += m_ksnap[i*KSIZE + j] * m_snap[r-i][c-j];
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_plane[r, c]) begin m_plane[r][c] = 0; m_res[r][c] = 0; m_pend[r][c] = 0; end
      foreach (m_kern[t]) m_kern[t] = 0;
      m_busy = 0; m_done = 0; m_rv = 0; m_left = 0; m_rd = '0;
    end else begin
      bit nd;
      m_rv = rd_en;
      if (rd_en) for (int c = 0; c < ARR; c++) m_rd[c*ACC_W +: ACC_W] = ACC_W'(m_res[rd_row][c]);
      if (m_done) m_res = m_pend;
      nd = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; nd = 1; end
      end else if (start) begin
        m_snap = m_plane;
        m_ksnap = m_kern;
        for (int r = 0; r < ARR; r++)
          for (int c = 0; c < ARR; c++) m_pend[r][c] = conv_at(r, c);
        m_busy = 1;
        m_left = TAPS;
      end
      m_done = nd;
      if (row_we) for (int c = 0; c < ARR; c++) m_plane[row_sel][c] = int'(row_data[c*PIX_W +: PIX_W]);
      if (col_we) for (int r = 0; r < ARR; r++) m_plane[r][col_sel] = int'(col_data[r*PIX_W +: PIX_W]);
      if (k_we) m_kern[k_addr] = int'(k_data);
    end
  end

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(cur_ctl, "busy", DW'(busy), DW'(m_busy));
      chk(cur_ctl, "done", DW'(done), DW'(m_done));
      chk("R7", "rd_valid", DW'(rd_valid), DW'(m_rv));
      if (m_rv) chk(cur_req, "rd_data", rd_data, m_rd);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fails++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [PIX_W-1:0] pat(int seed, int r, int c);
    return PIX_W'((seed * 37 + r * 53 + c * 19 + r * c * 7) % 256);
  endfunction

  task automatic idle_inputs();
    start = 0; k_we = 0; k_addr = '0; k_data = '0;
    row_we = 0; row_sel = '0; row_data = '0;
    col_we = 0; col_sel = '0; col_data = '0;
    rd_en = 0; rd_row = '0;
  endtask

  task automatic set_kernel(int mode);
    for (int t = 0; t < TAPS; t++) begin
      k_we = 1; k_addr = IDX_W'(t);
      case (mode)
        0: k_data = COEF_W'(((t * 29) % 41) - 20);
        1: k_data = COEF_W'(t * 3 - 11);
        2: k_data = -8'sd128;
        default: k_data = 8'sd127;
      endcase
      @(negedge clk);
    end
    k_we = 0;
  endtask

  task automatic load_rows(int seed, bit flat);
    for (int r = 0; r < ARR; r++) begin
      row_we = 1; row_sel = SEL_W'(r);
      for (int c = 0; c < ARR; c++) row_data[c*PIX_W +: PIX_W] = flat ? 8'hFF : pat(seed, r, c);
      @(negedge clk);
    end
    row_we = 0;
  endtask

  task automatic load_cols(int seed);
    for (int c = 0; c < ARR; c++) begin
      col_we = 1; col_sel = SEL_W'(c);
      for (int r = 0; r < ARR; r++) col_data[r*PIX_W +: PIX_W] = pat(seed, r, c);
      @(negedge clk);
    end
    col_we = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic read_all();
    for (int r = 0; r < ARR; r++) begin
      rd_en = 1; rd_row = SEL_W'(r); @(negedge clk);
    end
    rd_en = 0;
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy after reset", DW'(busy), '0);
    chk("R1", "done after reset", DW'(done), '0);
    chk("R1", "rd_valid after reset", DW'(rd_valid), '0);
    checking = 1;
    cur_req = "R1";
    read_all();

    // R8 + R2: asymmetric kernel, tile loaded over the row bus (R5)
    cur_req = "R8";
    set_kernel(0);
    load_rows(1, 0);
    pulse_start();
    // R6: next tile over the column bus while this one computes
    load_cols(2);
    wait_done();
    // R3 back-to-back: start in the done cycle
    pulse_start();
    cur_req = "R7";
    read_all();
    wait_done();
    cur_req = "R6";
    read_all();

    // R4: extra start while busy is ignored
    cur_ctl = "R4";
    cur_req = "R4";
    load_rows(3, 0);
    pulse_start();
    @(negedge clk);
    pulse_start();
    wait_done();
    read_all();
    cur_ctl = "R3";

    // R5: row and column buses in one cycle, crossing element
    cur_req = "R5";
    row_we = 1; row_sel = SEL_W'(1); col_we = 1; col_sel = SEL_W'(2);
    for (int k = 0; k < ARR; k++) begin
      row_data[k*PIX_W +: PIX_W] = PIX_W'(200 + k);
      col_data[k*PIX_W +: PIX_W] = PIX_W'(10 + 3 * k);
    end
    @(negedge clk);
    row_we = 0; col_we = 0;
    // R6: write in the start cycle belongs to the next tile
    start = 1; row_we = 1; row_sel = '0; row_data = '1;
    @(negedge clk);
    start = 0; row_we = 0;
    wait_done();
    read_all();

    // R9: restart with no reload, new kernel
    cur_req = "R9";
    set_kernel(1);
    pulse_start();
    wait_done();
    read_all();

    // R2: extreme values, no saturation
    cur_req = "R2";
    load_rows(0, 1);
    set_kernel(2);
    pulse_start();
    wait_done();
    read_all();
    set_kernel(3);
    pulse_start();
    wait_done();
    read_all();

    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule